// File: doc/BRIEF.md
# Single-Operand ALU with Condition Flags

This block performs the one-operand operations of a 16-bit minicomputer datapath in a single pipeline stage. Each accepted request carries an operation code, a byte/word selector, the operand and the current N, Z, V and C flags. One clock later the block presents the new operand value and the next flags. Every operation follows its own rule for the four flags. Operand fetch, address calculation and storing the result belong to neighbouring blocks.

Both sides of the block use a valid/ready stream. A request transfers on a rising edge where `in_valid` and `in_ready` are both high. A result transfers on a rising edge where `out_valid` and `out_ready` are both high. The block holds one result at most. `in_ready` equals `!out_valid || out_ready`, so a new request can enter in the same cycle that the held result leaves. While `out_ready` is low, a held result and its flags stay unchanged and no new request is accepted. With `out_ready` tied high, the block accepts one request per cycle and `out_valid` goes high exactly one cycle after each accepted request.

Top module: `unary_alu`

## Requirements
- R1: Op 0 (clear) gives a result of 0, sets Z, and clears N, V and C.
- R2: Op 1 (increment) and op 2 (decrement) take N and Z from the result. V is set only when the operand was the largest positive value (increment) or the most negative value (decrement). C keeps its input value.
- R3: Op 3 adds the input C to the operand and sets C to the carry out. Op 4 subtracts the input C and sets C when a borrow occurs. V is set when the operand moves across the signed boundary, that is, from largest positive to negative for op 3, or from most negative to positive for op 4.
- R4: Op 5 (test) returns the operand unchanged, takes N and Z from it, and clears V and C. Op 7 (complement) returns the bitwise inverse, takes N and Z from the result, clears V and sets C.
- R5: Op 6 (negate) returns the two's complement of the operand. V is set only when the operand is the most negative value. C is set exactly when the result is nonzero.
- R6: Op 8 rotates right and op 9 rotates left, both through C. C receives the bit that leaves the operand. V equals new N XOR new C.
- R7: Op 10 shifts right arithmetically and sets C to the old bit 0. Op 11 shifts left, fills with 0, and sets C to the old top bit. For both, V equals new N XOR new C.
- R8: Op 12 swaps the two bytes of the word. N comes from bit 7 of the result and Z from the result's low byte being zero. V and C are cleared. The byte selector has no effect on this op.
- R9: Op 13 writes all ones when the input N is 1 and all zeros otherwise. It sets Z from that result and passes N, V and C through unchanged. The byte selector has no effect on this op.
- R10: In byte mode (`in_byte`=1, ops 0 to 11), only bits 7:0 are operated on, and result bits 15:8 equal operand bits 15:8. N comes from bit 7, Z is set when bits 7:0 are zero, and carry and overflow are judged at 8 bits.
- R11: Op codes 14 and 15 return the operand unchanged and pass all four flags through unchanged.
- R12: The flag buses are ordered {N,Z,V,C} from bit 3 down to bit 0. `out_valid` rises on the cycle after an accepted request. `in_ready` is `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result` and `out_flags` hold their values.
- R13: A synchronous reset clears `out_valid`, `out_result` and `out_flags` to zero and discards any held result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 4 | Operation code |
| in_byte | input | 1 | 1 selects byte width |
| in_data | input | 16 | Operand |
| in_flags | input | 4 | Current {N,Z,V,C} |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 16 | New operand value |
| out_flags | output | 4 | Next {N,Z,V,C} |

## Verification
The only state inside the block is the output stage. If that stage is wrong, the fault appears at the ports at the next handshake. A dropped or repeated result shows up as a mismatch against the expected-result queue, or as a result arriving when none is expected. If the held data changes during a stall, `out_result` changes while `out_ready` is low. An error in a flag rule appears one cycle after the offending request. For that reason the bench covers each operation's boundary operands at both widths.

// File: rtl/ua_pkg.sv
package ua_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_CLR  = 4'd0,
    OP_INC  = 4'd1,
    OP_DEC  = 4'd2,
    OP_ADC  = 4'd3,
    OP_SBC  = 4'd4,
    OP_TST  = 4'd5,
    OP_NEG  = 4'd6,
    OP_COM  = 4'd7,
    OP_ROR  = 4'd8,
    OP_ROL  = 4'd9,
    OP_ASR  = 4'd10,
    OP_ASL  = 4'd11,
    OP_SWAB = 4'd12,
    OP_SXT  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } ua_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ua_flags_t;
endpackage

// File: rtl/ua_core.sv
module ua_core
  import ua_pkg::*;
#(
  parameter int W = 16
) (
  input  ua_op_e       op,
  input  logic [W-1:0] a,
  input  ua_flags_t    fin,
  output logic [W-1:0] r,
  output ua_flags_t    fout
);
  localparam int H = W / 2;
  localparam logic [W-1:0] MAXPOS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINNEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONE    = {{(W-1){1'b0}}, 1'b1};

  logic [W:0] ext_sum;
  logic [W:0] ext_dif;
  logic       nz_gen;
  logic       v_from_nc;

  always_comb begin
    ext_sum   = {1'b0, a} + {{W{1'b0}}, fin.c};
    ext_dif   = {1'b0, a} - {{W{1'b0}}, fin.c};
    r         = a;
    fout      = fin;
    nz_gen    = 1'b1;
    v_from_nc = 1'b0;
    case (op)
      OP_CLR: begin
        r = '0;
        fout.v = 1'b0;
        fout.c = 1'b0;
      end
      OP_INC: begin
        r = a + ONE;
        fout.v = (a == MAXPOS);
      end
      OP_DEC: begin
        r = a - ONE;
        fout.v = (a == MINNEG);
      end
      OP_ADC: begin
        r = ext_sum[W-1:0];
        fout.c = ext_sum[W];
        fout.v = (a == MAXPOS) && fin.c;
      end
      OP_SBC: begin
        r = ext_dif[W-1:0];
        fout.c = ext_dif[W];
        fout.v = (a == MINNEG) && fin.c;
      end
      OP_TST: begin
        fout.v = 1'b0;
        fout.c = 1'b0;
      end
      OP_NEG: begin
        r = '0 - a;
        fout.v = (a == MINNEG);
        fout.c = |a;
      end
      OP_COM: begin
        r = ~a;
        fout.v = 1'b0;
        fout.c = 1'b1;
      end
      OP_ROR: begin
        r = {fin.c, a[W-1:1]};
        fout.c = a[0];
        v_from_nc = 1'b1;
      end
      OP_ROL: begin
        r = {a[W-2:0], fin.c};
        fout.c = a[W-1];
        v_from_nc = 1'b1;
      end
      OP_ASR: begin
        r = {a[W-1], a[W-1:1]};
        fout.c = a[0];
        v_from_nc = 1'b1;
      end
      OP_ASL: begin
        r = {a[W-2:0], 1'b0};
        fout.c = a[W-1];
        v_from_nc = 1'b1;
      end
      OP_SWAB: begin
        r = {a[H-1:0], a[W-1:H]};
        nz_gen = 1'b0;
        fout.n = a[W-1];
        fout.z = ~|a[W-1:H];
        fout.v = 1'b0;
        fout.c = 1'b0;
      end
      OP_SXT: begin
        r = {W{fin.n}};
        nz_gen = 1'b0;
        fout.z = ~fin.n;
      end
      default: nz_gen = 1'b0;
    endcase
    if (nz_gen) begin
      fout.n = r[W-1];
      fout.z = ~|r;
    end
    if (v_from_nc) fout.v = fout.n ^ fout.c;
  end
endmodule

// File: rtl/ua_outreg.sv
module ua_outreg
  import ua_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d_result,
  input  ua_flags_t    d_flags,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q_result,
  output ua_flags_t    q_flags
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      q_result  <= '0;
      q_flags   <= '0;
    end else begin
      if (take) begin
        q_result <= d_result;
        q_flags  <= d_flags;
      end
      if (take)           out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  // R12
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(q_result) && $stable(q_flags)));
endmodule

// File: rtl/unary_alu.sv
module unary_alu
  import ua_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic              in_byte,
  input  logic [DATA_W-1:0] in_data,
  input  logic [3:0]        in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [3:0]        out_flags
);
  localparam int HALF_W = DATA_W / 2;

  ua_op_e            op_e;
  ua_flags_t         fin;
  logic [DATA_W-1:0] word_r;
  ua_flags_t         word_f;
  logic [HALF_W-1:0] byte_r;
  ua_flags_t         byte_f;
  logic              use_byte;
  logic [DATA_W-1:0] sel_r;
  ua_flags_t         sel_f;
  ua_flags_t         q_f;

  assign op_e = ua_op_e'(in_op);
  assign fin  = ua_flags_t'(in_flags);

  ua_core #(.W(DATA_W)) word_core_i (
    .op(op_e), .a(in_data), .fin(fin), .r(word_r), .fout(word_f)
  );

  ua_core #(.W(HALF_W)) byte_core_i (
    .op(op_e), .a(in_data[HALF_W-1:0]), .fin(fin), .r(byte_r), .fout(byte_f)
  );

  // swap and sign-extend are word-only operations
  assign use_byte = in_byte && (op_e != OP_SWAB) && (op_e != OP_SXT);
  assign sel_r    = use_byte ? {in_data[DATA_W-1:HALF_W], byte_r} : word_r;
  assign sel_f    = use_byte ? byte_f : word_f;

  ua_outreg #(.W(DATA_W)) out_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .d_result(sel_r), .d_flags(sel_f),
    .out_valid(out_valid), .out_ready(out_ready),
    .q_result(out_result), .q_flags(q_f)
  );

  assign out_flags = q_f;

  logic accepted;
  assign accepted = in_valid && in_ready;

  // R1
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (accepted && op_e == OP_CLR && !in_byte) |=> (out_result == '0 && out_flags == 4'b0100));

  // R4
  com_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (accepted && op_e == OP_COM) |=> (out_flags[0] && !out_flags[1]));

  // R5
  neg_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (accepted && op_e == OP_NEG && !in_byte) |=> (out_flags[0] == (out_result != '0)));

  // R6 R7
  shift_v_chk: assert property (@(posedge clk) disable iff (rst)
    (accepted && (op_e == OP_ROR || op_e == OP_ROL || op_e == OP_ASR || op_e == OP_ASL))
    |=> (out_flags[1] == (out_flags[3] ^ out_flags[0])));

  // R11
  reserved_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (accepted && (op_e == OP_RSV0 || op_e == OP_RSV1)) |=> (out_flags == $past(in_flags)));
endmodule

// File: tb/unary_alu_tb_top.sv
`timescale 1ns/1ps
module unary_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic        in_byte = 1'b0;
  logic [15:0] in_data = '0;
  logic [3:0]  in_flags = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_result;
  logic [3:0]  out_flags;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit stall_all = 1'b0;
  bit jitter    = 1'b0;
  bit done      = 1'b0;

  logic [15:0] q_res[$];
  logic [3:0]  q_fl[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  unary_alu dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_byte(in_byte), .in_data(in_data), .in_flags(in_flags),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_flags(out_flags)
  );

  function automatic logic [19:0] model(input int op, input bit byt, input int a, input logic [3:0] fi);
    int w, mask, sgn, x, r, t;
    bit n, z, v, c, ni, vi, ci;
    ni = fi[3]; vi = fi[1]; ci = fi[0];
    w = (byt && op < 12) ? 8 : 16;
    mask = (1 << w) - 1;
    sgn = 1 << (w - 1);
    x = a & mask;
    r = x;
    case (op)
      0: r = 0;
      1: r = (x + 1) & mask;
      2: r = (x - 1) & mask;
      3: r = (x + ci) & mask;
      4: r = (x - ci) & mask;
      6: r = (-x) & mask;
      7: r = (~x) & mask;
      8: r = (x >> 1) | (ci ? sgn : 0);
      9: r = ((x << 1) & mask) | ci;
      10: r = (x >> 1) | (x & sgn);
      11: r = (x << 1) & mask;
      12: r = ((x & 255) << 8) | (x >> 8);
      13: r = ni ? mask : 0;
      default: r = x;
    endcase
    n = (r & sgn) != 0;
    z = (r == 0);
    v = vi; c = ci;
    case (op)
      0: begin v = 0; c = 0; end
      1: v = (x == sgn - 1);
      2: v = (x == sgn);
      3: begin t = x + ci; c = (t > mask); v = (x == sgn - 1) && ci; end
      4: begin t = x - ci; c = (t < 0); v = (x == sgn) && ci; end
      5: begin v = 0; c = 0; end
      6: begin v = (x == sgn); c = (r != 0); end
      7: begin v = 0; c = 1; end
      8, 10: begin c = x[0]; v = n ^ c; end
      9, 11: begin c = (x & sgn) != 0; v = n ^ c; end
      12: begin n = (r & 128) != 0; z = (r & 255) == 0; v = 0; c = 0; end
      13: n = ni;
      14, 15: begin n = ni; z = fi[2]; end
      default: ;
    endcase
    if (w == 8) r = (a & 16'hFF00) | r;
    model = {r[15:0], n, z, v, c};
  endfunction

  function automatic string tag_of(input int op, input bit byt);
    if (byt && op < 12) return "R10";
    case (op)
      0: return "R1";
      1, 2: return "R2";
      3, 4: return "R3";
      5, 7: return "R4";
      6: return "R5";
      8, 9: return "R6";
      10, 11: return "R7";
      12: return "R8";
      13: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input int op, input bit byt, input logic [15:0] a, input logic [3:0] fi);
    logic [19:0] e;
    @(negedge clk); #1;
    in_op = op[3:0]; in_byte = byt; in_data = a; in_flags = fi; in_valid = 1'b1;
    while (!in_ready) begin @(negedge clk); #1; end
    e = model(op, byt, int'(a), fi);
    q_res.push_back(e[19:4]);
    q_fl.push_back(e[3:0]);
    q_tag.push_back(tag_of(op, byt));
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // monitor: decide ready for the coming edge, then score what transfers there
  always @(negedge clk) begin
    cyc++;
    out_ready = stall_all ? 1'b0 : (jitter ? (cyc % 3 != 0) : 1'b1);
    if (!rst && out_valid && out_ready) begin
      if (q_res.size() == 0) begin
        checks++; fails++;
        $display("FAIL R12 actual=unexpected result %h expected=none", out_result);
      end else begin
        check(q_tag.pop_front(), {out_result, out_flags}, {q_res.pop_front(), q_fl.pop_front()});
      end
    end
  end

  task automatic drain();
    int guard = 0;
    while (q_res.size() != 0 && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13: reset state
    check("R13", {out_valid, 3'b0, out_result, out_flags}, 24'h0);

    // R1 clear, word and byte
    send(0, 0, 16'hBEEF, 4'b1011);
    send(0, 1, 16'hBEEF, 4'b1011);
    // R2 increment/decrement boundaries
    send(1, 0, 16'h7FFF, 4'b0001);
    send(1, 0, 16'hFFFF, 4'b0000);
    send(2, 0, 16'h8000, 4'b0001);
    send(2, 0, 16'h0001, 4'b0000);
    // R3 add/subtract carry
    send(3, 0, 16'hFFFF, 4'b0001);
    send(3, 0, 16'h7FFF, 4'b0001);
    send(4, 0, 16'h0000, 4'b0001);
    send(4, 0, 16'h8000, 4'b0001);
    // R4 test and complement
    send(5, 0, 16'h8001, 4'b0011);
    send(7, 0, 16'h00FF, 4'b0000);
    // R5 negate
    send(6, 0, 16'h8000, 4'b0000);
    send(6, 0, 16'h0000, 4'b0001);
    send(6, 0, 16'h0005, 4'b0000);
    // R6 rotates
    send(8, 0, 16'h0001, 4'b0000);
    send(9, 0, 16'h8000, 4'b0001);
    // R7 shifts
    send(10, 0, 16'h8001, 4'b0000);
    send(11, 0, 16'h4000, 4'b0000);
    // R8 swap, byte flag has no effect
    send(12, 0, 16'h8000, 4'b0011);
    send(12, 1, 16'h00FF, 4'b0000);
    // R9 sign extend
    send(13, 0, 16'h1234, 4'b1011);
    send(13, 1, 16'h1234, 4'b0100);
    // R10 byte forms
    send(1, 1, 16'hAB7F, 4'b0000);
    send(3, 1, 16'hCDFF, 4'b0001);
    send(6, 1, 16'h1280, 4'b0000);
    send(9, 1, 16'h3480, 4'b0000);
    // R11 reserved codes
    send(14, 0, 16'h5A5A, 4'b1010);
    send(15, 1, 16'hA5A5, 4'b0101);
    drain();

    // R12 single request: valid for exactly one cycle
    send(5, 0, 16'h0042, 4'b0000);
    @(negedge clk);
    check("R12", {19'b0, out_valid}, 20'h1);
    @(negedge clk);
    check("R12", {19'b0, out_valid}, 20'h0);

    // R12 back-pressure: held result stays put, input blocked
    stall_all = 1'b1;
    send(7, 0, 16'h1111, 4'b0000);
    @(negedge clk); held = out_result;
    repeat (3) @(negedge clk);
    check("R12", {out_valid, in_ready, 2'b0, out_result}, {1'b1, 1'b0, 2'b0, held});
    stall_all = 1'b0;
    drain();

    // R13 mid-run reset drops held result
    stall_all = 1'b1;
    send(1, 0, 16'h0100, 4'b0000);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    q_res.delete(); q_fl.delete(); q_tag.delete();
    check("R13", {out_valid, 3'b0, out_result, out_flags}, 24'h0);
    stall_all = 1'b0;

    // random sweep with irregular consumer
    jitter = 1'b1;
    for (int i = 0; i < 400; i++) begin
      send(int'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
           16'($urandom), 4'($urandom));
    end
    jitter = 1'b0;
    drain();
    if (q_res.size() != 0) begin
      checks++; fails++;
      $display("FAIL R12 actual=%0d pending expected=0", q_res.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R12 actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule